// File: doc/BRIEF.md
# Fetch Breakpoint Injector

This block sits beside the instruction fetch stage and decides, for every fetch address, whether the word handed to decode comes from memory or is replaced. A debugger manages a small table of hardware breakpoint addresses with two commands, insert and delete, and never needs to know slot numbers. When the fetch address matches a live table entry, the block substitutes the 32-bit breakpoint-trap encoding so that the core stops without any patch to memory.

A second, independent facility pairs one substitute address with one arbitrary instruction word. When it is enabled and the fetch address equals the programmed address, the programmed word is handed on in place of memory data. A debugger uses this to execute the original instruction at a breakpoint location without rewriting memory. All configuration is written through a single register write port. The instruction output is combinational from the fetch address, and configuration writes are registered.

Top module: `hw_bkpt_fetch`

## Requirements
- R1: After reset every table entry is empty, the substitute address and word are zero with the substitute facility disabled, `overflow_o` is 0, and `instr_o` equals `mem_instr_i` for any fetch address, zero included.
- R2: A write with `reg_sel_i`=0 inserts `reg_wdata_i` into the breakpoint table, and a later fetch of that address raises `bkpt_hit_o`.
- R3: While `bkpt_hit_o` is 1, `instr_o` is 64'h0000_0000_0010_0073 (the trap encoding, zero-extended).
- R4: A write with `reg_sel_i`=1 deletes the entry equal to `reg_wdata_i`. Deleting an address that is not in the table changes nothing.
- R5: Inserting an address that is already in the table creates no second entry, so a single delete removes it.
- R6: With all `NUM_BKPT` entries in use, inserting a new address is dropped and sets `overflow_o`. `overflow_o` stays set until reset, even after entries are freed. Re-inserting an address already present in a full table does not set it.
- R7: Writes with `reg_sel_i`=2, 3 and 4 load the substitute address, the substitute word and the enable bit (`reg_wdata_i[0]`). When the facility is enabled and the fetch address equals the substitute address, `ovr_hit_o` is 1 and `instr_o` equals the substitute word.
- R8: While the substitute facility is disabled, `ovr_hit_o` stays 0 and no substitution takes place, even when the fetch address equals the stored substitute address.
- R9: When a table entry and the enabled substitute address both match, the trap encoding wins.
- R10: When neither hit is active, `instr_o` equals `mem_instr_i`.
- R11: A configuration write affects `instr_o` only after the clock edge that captures it, never during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 insert, 1 delete, 2 substitute address, 3 substitute word, 4 enable |
| reg_wdata_i | input | XLEN | Write data |
| fetch_pc_i | input | XLEN | Current fetch address |
| mem_instr_i | input | XLEN | Instruction word read from memory |
| instr_o | output | XLEN | Instruction word handed to decode |
| bkpt_hit_o | output | 1 | Fetch address matches a table entry |
| ovr_hit_o | output | 1 | Fetch address matches the enabled substitute address |
| overflow_o | output | 1 | Sticky: an insert was dropped because the table was full |

## Verification
The hardest condition to reach is a full table. In that state the block must tell a fresh address, which is dropped and raises the sticky flag, from one that is already present, which is quietly accepted. The stimulus fills every slot with distinct addresses, re-inserts one of them and checks that the flag is still clear. It then inserts a fresh address, checks that it does not hit, frees a slot, and confirms that the flag persists while the previously dropped address can now be inserted. Same-cycle timing is covered by holding the fetch address at the target during the write cycle itself.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  typedef enum logic [2:0] {
    REG_ADD       = 3'd0,
    REG_REMOVE    = 3'd1,
    REG_OVR_ADDR  = 3'd2,
    REG_OVR_INSTR = 3'd3,
    REG_OVR_CTRL  = 3'd4
  } hbf_reg_e;

  localparam logic [31:0] EBREAK_WORD = 32'h0010_0073;
endpackage

// File: rtl/hbf_bkpt_table.sv
module hbf_bkpt_table #(
  parameter int NUM_BKPT = 8,
  parameter int XLEN     = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            add_i,
  input  logic            rem_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            hit_o,
  output logic            overflow_o
);
  logic [NUM_BKPT-1:0] vld_q;
  logic [XLEN-1:0]     addr_q [NUM_BKPT];
  logic [NUM_BKPT-1:0] wr_match, pc_match, free_sel;
  logic                present, full, taken, ovf_q;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_entry
    assign wr_match[g] = vld_q[g] && (addr_q[g] == wdata_i);
    assign pc_match[g] = vld_q[g] && (addr_q[g] == pc_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
      end else if (add_i && !present && free_sel[g]) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= wdata_i;
      end else if (rem_i && wr_match[g]) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  // lowest free slot, one-hot
  always_comb begin
    free_sel = '0;
    taken    = 1'b0;
    for (int i = 0; i < NUM_BKPT; i++) begin
      if (!vld_q[i] && !taken) begin
        free_sel[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  assign present = |wr_match;
  assign full    = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (add_i && !present && full) ovf_q <= 1'b1;
  end

  assign hit_o      = |pc_match;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/hbf_ovr_regs.sv
module hbf_ovr_regs #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_we_i,
  input  logic            instr_we_i,
  input  logic            en_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            en_d_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            hit_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] instr_o,
  output logic            en_o
);
  logic [XLEN-1:0] addr_q, instr_q;
  logic            en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      instr_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (addr_we_i)  addr_q  <= wdata_i;
      if (instr_we_i) instr_q <= wdata_i;
      if (en_we_i)    en_q    <= en_d_i;
    end
  end

  assign hit_o   = en_q && (pc_i == addr_q);
  assign addr_o  = addr_q;
  assign instr_o = instr_q;
  assign en_o    = en_q;
endmodule

// File: rtl/hbf_fetch_mux.sv
module hbf_fetch_mux #(
  parameter int XLEN = 64
) (
  input  logic            bkpt_hit_i,
  input  logic            ovr_hit_i,
  input  logic [XLEN-1:0] ovr_instr_i,
  input  logic [XLEN-1:0] mem_instr_i,
  output logic [XLEN-1:0] instr_o
);
  localparam logic [XLEN-1:0] TRAP_WORD = XLEN'(hbf_pkg::EBREAK_WORD);

  always_comb begin
    if (bkpt_hit_i)     instr_o = TRAP_WORD;
    else if (ovr_hit_i) instr_o = ovr_instr_i;
    else                instr_o = mem_instr_i;
  end
endmodule

// File: rtl/hw_bkpt_fetch.sv
module hw_bkpt_fetch #(
  parameter int NUM_BKPT = 8,
  parameter int XLEN     = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_sel_i,
  input  logic [XLEN-1:0] reg_wdata_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic [XLEN-1:0] mem_instr_i,
  output logic [XLEN-1:0] instr_o,
  output logic            bkpt_hit_o,
  output logic            ovr_hit_o,
  output logic            overflow_o
);
  import hbf_pkg::*;

  hbf_reg_e        sel;
  logic            add_we, rem_we, oaddr_we, oinstr_we, oen_we;
  logic [XLEN-1:0] ovr_addr, ovr_instr;
  logic            ovr_en;

  assign sel       = hbf_reg_e'(reg_sel_i);
  assign add_we    = reg_we_i && (sel == REG_ADD);
  assign rem_we    = reg_we_i && (sel == REG_REMOVE);
  assign oaddr_we  = reg_we_i && (sel == REG_OVR_ADDR);
  assign oinstr_we = reg_we_i && (sel == REG_OVR_INSTR);
  assign oen_we    = reg_we_i && (sel == REG_OVR_CTRL);

  hbf_bkpt_table #(.NUM_BKPT(NUM_BKPT), .XLEN(XLEN)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_i      (add_we),
    .rem_i      (rem_we),
    .wdata_i    (reg_wdata_i),
    .pc_i       (fetch_pc_i),
    .hit_o      (bkpt_hit_o),
    .overflow_o (overflow_o)
  );

  hbf_ovr_regs #(.XLEN(XLEN)) u_ovr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_we_i  (oaddr_we),
    .instr_we_i (oinstr_we),
    .en_we_i    (oen_we),
    .wdata_i    (reg_wdata_i),
    .en_d_i     (reg_wdata_i[0]),
    .pc_i       (fetch_pc_i),
    .hit_o      (ovr_hit_o),
    .addr_o     (ovr_addr),
    .instr_o    (ovr_instr),
    .en_o       (ovr_en)
  );

  hbf_fetch_mux #(.XLEN(XLEN)) u_mux (
    .bkpt_hit_i  (bkpt_hit_o),
    .ovr_hit_i   (ovr_hit_o),
    .ovr_instr_i (ovr_instr),
    .mem_instr_i (mem_instr_i),
    .instr_o     (instr_o)
  );
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [2:0]      reg_sel_i,
  input logic [XLEN-1:0] reg_wdata_i,
  input logic [XLEN-1:0] fetch_pc_i,
  input logic [XLEN-1:0] mem_instr_i,
  input logic [XLEN-1:0] instr_o,
  input logic            bkpt_hit_o,
  input logic            ovr_hit_o,
  input logic            overflow_o,
  input logic [XLEN-1:0] ovr_instr_i,
  input logic            ovr_en_i
);
  localparam logic [XLEN-1:0] TRAP = XLEN'(hbf_pkg::EBREAK_WORD);

  p_trap_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_hit_o |-> instr_o == TRAP);

  p_removed_gone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 3'd1) |=> !(bkpt_hit_o && fetch_pc_i == $past(reg_wdata_i)));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(reg_we_i && reg_sel_i == 3'd0));

  p_overflow_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_subst_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_hit_o && !bkpt_hit_o) |-> instr_o == ovr_instr_i);

  p_subst_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_en_i |-> !ovr_hit_o);

  p_passthru_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bkpt_hit_o && !ovr_hit_o) |-> instr_o == mem_instr_i);
endmodule

bind hw_bkpt_fetch hbf_checker #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .fetch_pc_i  (fetch_pc_i),
  .mem_instr_i (mem_instr_i),
  .instr_o     (instr_o),
  .bkpt_hit_o  (bkpt_hit_o),
  .ovr_hit_o   (ovr_hit_o),
  .overflow_o  (overflow_o),
  .ovr_instr_i (ovr_instr),
  .ovr_en_i    (ovr_en)
);

// File: tb/hw_bkpt_fetch_tb_top.sv
module hw_bkpt_fetch_tb_top;
  localparam int N    = 8;
  localparam int XLEN = 64;
  localparam logic [63:0] TRAP = 64'h0000_0000_0010_0073;
  localparam logic [63:0] MEMW = 64'h1111_2222_3333_4444;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            reg_we_i = 1'b0;
  logic [2:0]      reg_sel_i = '0;
  logic [XLEN-1:0] reg_wdata_i = '0;
  logic [XLEN-1:0] fetch_pc_i = '0;
  logic [XLEN-1:0] mem_instr_i = MEMW;
  logic [XLEN-1:0] instr_o;
  logic            bkpt_hit_o, ovr_hit_o, overflow_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  hw_bkpt_fetch #(.NUM_BKPT(N), .XLEN(XLEN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .fetch_pc_i(fetch_pc_i), .mem_instr_i(mem_instr_i),
    .instr_o(instr_o), .bkpt_hit_o(bkpt_hit_o), .ovr_hit_o(ovr_hit_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    reg_we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // drive at negedge, captured at next posedge, returns at following negedge
  task automatic wr(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic look(input logic [63:0] pc);
    fetch_pc_i = pc;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    look(64'h0);
    chk("R1 instr at pc0", instr_o, MEMW);
    chk("R1 bkpt_hit", 64'(bkpt_hit_o), 64'd0);
    chk("R1 ovr_hit", 64'(ovr_hit_o), 64'd0);
    chk("R1 overflow", 64'(overflow_o), 64'd0);
  endtask

  task automatic t_add_remove();
    wr(3'd0, 64'h1000);
    look(64'h1000);
    chk("R2 hit after add", 64'(bkpt_hit_o), 64'd1);
    chk("R3 trap word", instr_o, TRAP);
    mem_instr_i = 64'hAAAA_0000_0000_0013;
    look(64'h1004);
    chk("R10 passthrough", instr_o, 64'hAAAA_0000_0000_0013);
    mem_instr_i = MEMW;
    wr(3'd1, 64'h1000);
    look(64'h1000);
    chk("R4 removed", 64'(bkpt_hit_o), 64'd0);
    chk("R4 removed instr", instr_o, MEMW);
    wr(3'd0, 64'h3000);
    wr(3'd1, 64'h5000);
    look(64'h3000);
    chk("R4 absent remove no effect", instr_o, TRAP);
  endtask

  task automatic t_timing();
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = 3'd0; reg_wdata_i = 64'h7000;
    fetch_pc_i = 64'h7000;
    #1;
    chk("R11 no hit in write cycle", instr_o, MEMW);
    @(posedge clk_i);
    #1;
    chk("R11 hit after edge", instr_o, TRAP);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic t_dup();
    wr(3'd0, 64'h9000);
    wr(3'd0, 64'h9000);
    wr(3'd1, 64'h9000);
    look(64'h9000);
    chk("R5 single delete clears dup add", 64'(bkpt_hit_o), 64'd0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < N; i++) wr(3'd0, 64'h100 + 64'(i) * 8);
    for (int i = 0; i < N; i++) begin
      look(64'h100 + 64'(i) * 8);
      chk("R2 full table entry hits", 64'(bkpt_hit_o), 64'd1);
    end
    wr(3'd0, 64'h108);
    chk("R6 re-add present when full no overflow", 64'(overflow_o), 64'd0);
    wr(3'd0, 64'hF00);
    chk("R6 overflow set", 64'(overflow_o), 64'd1);
    look(64'hF00);
    chk("R6 dropped add no hit", 64'(bkpt_hit_o), 64'd0);
    wr(3'd1, 64'h110);
    chk("R6 overflow sticky", 64'(overflow_o), 64'd1);
    wr(3'd0, 64'hF00);
    look(64'hF00);
    chk("R6 add after free hits", 64'(bkpt_hit_o), 64'd1);
    do_reset();
    chk("R1 overflow cleared by reset", 64'(overflow_o), 64'd0);
  endtask

  task automatic t_override();
    do_reset();
    wr(3'd2, 64'h2000);
    wr(3'd3, 64'hDEAD_BEEF_0000_0013);
    look(64'h2000);
    chk("R8 disabled no subst", instr_o, MEMW);
    chk("R8 disabled ovr_hit", 64'(ovr_hit_o), 64'd0);
    wr(3'd4, 64'h1);
    look(64'h2000);
    chk("R7 subst word", instr_o, 64'hDEAD_BEEF_0000_0013);
    chk("R7 ovr_hit", 64'(ovr_hit_o), 64'd1);
    look(64'h2008);
    chk("R10 other pc passthrough", instr_o, MEMW);
    wr(3'd0, 64'h2000);
    look(64'h2000);
    chk("R9 table beats subst", instr_o, TRAP);
    wr(3'd1, 64'h2000);
    wr(3'd4, 64'h0);
    look(64'h2000);
    chk("R8 disabled again", instr_o, MEMW);
  endtask

  initial begin
    t_reset();
    t_add_remove();
    t_timing();
    t_dup();
    t_full();
    t_override();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule